// File: doc/BRIEF.md
# Quadword Read-Modify-Write Access Adapter

This adapter lets a requester issue byte, halfword, word and quadword loads and stores to a memory that only moves whole 128-bit lines at 16-byte-aligned addresses. The memory has no byte enables.

A narrow load fetches the line that holds the addressed bytes. It then picks out those bytes and returns them zero-extended. A narrow store also fetches the line first, keeps one registered copy of it, and overwrites only the addressed byte lanes under a generated mask. It then writes the whole line back. A quadword store has no bytes to preserve, so it skips the fetch and writes at once.

The adapter takes one request at a time. It holds `req_ready` low until the sequence for that request is finished. A request that is not naturally aligned touches no memory. It produces only a one-cycle fault pulse.

Top module: `qw_rmw_adapter`

## Requirements
- R1: Every memory transfer uses the request address with bits [3:0] cleared, so `mem_addr[3:0]` is always zero, and always moves a whole 128-bit line.
- R2: `req_size` encodes the access width: 00 is byte, 01 is halfword, 10 is word and 11 is quadword. A halfword needs `addr[0]==0`, a word needs `addr[1:0]==0` and a quadword needs `addr[3:0]==0`. A byte is never misaligned.
- R3: A misaligned request raises `rsp_fault` for exactly the cycle after it is accepted. It causes no memory read or write and no `rsp_valid`, and the adapter stays ready.
- R4: A narrow load reads the line once, in the cycle after acceptance. It asserts `rsp_valid` three cycles after acceptance. `rsp_data` then holds the bytes starting at lane `addr[3:0]` with lane 0 at bits [7:0], zero-extended to 32 bits. For example, a halfword at address 2 returns bytes 2 and 3.
- R5: A quadword load returns all 16 bytes on `rsp_qdata`, with lane i at bits [8i+7:8i], when `rsp_valid` is high.
- R6: A narrow store reads the line, then writes back a line in which only the addressed lanes take the low bytes of `req_wdata`. It asserts `rsp_valid` four cycles after acceptance.
- R7: A quadword store performs no read. It writes `req_wdata` in the cycle after acceptance and asserts `rsp_valid` two cycles after acceptance.
- R8: `req_ready` is high only while the adapter is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high.
- R9: While reset is asserted and directly after it, `req_ready` is high and `rsp_valid`, `rsp_fault`, `mem_rd_en` and `mem_wr_en` are low.
- R10: Memory reads and writes never occur in the same cycle. A narrow store writes exactly two cycles after its single read, and the written line is built from that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter idle and able to accept |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access width code |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 128 | Store data, low bytes used for narrow stores |
| rsp_valid | output | 1 | Access completed |
| rsp_fault | output | 1 | Alignment fault pulse |
| rsp_data | output | 32 | Zero-extended narrow load result |
| rsp_qdata | output | 128 | Quadword load result |
| mem_rd_en | output | 1 | Line read strobe |
| mem_wr_en | output | 1 | Line write strobe |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wdata | output | 128 | Line to write |
| mem_rdata | input | 128 | Line read, valid one cycle after the read strobe |

## Verification
Assertions check four properties on every cycle: the line alignment of each memory address, the exclusion of reads and writes in the same cycle, and the silence of the memory and response ports while the adapter is idle or faulting. They also check the cycle in which a quadword store writes and a narrow access reads. Only the bench scenarios can show that the right bytes come back and that neighbouring lanes survive a store. The bench covers this by mirroring the memory as a byte array and comparing every load result and, at the end, every line.

// File: rtl/qw_rmw_pkg.sv
package qw_rmw_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_QUAD = 2'b11
    } acc_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_MERGE,
        ST_WRITE,
        ST_DONE
    } fsm_e;
endpackage

// File: rtl/qw_lane_mask.sv
module qw_lane_mask
    import qw_rmw_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    localparam int OFF_W = $clog2(LINE_BYTES)
) (
    input  acc_size_e              size,
    input  logic [OFF_W-1:0]       off,
    output logic [LINE_BYTES-1:0]  lane_mask,
    output logic                   misaligned
);
    localparam int CNT_W = OFF_W + 1;

    logic [CNT_W-1:0] nbytes;
    logic [CNT_W-1:0] off_x;

    always_comb begin
        unique case (size)
            SZ_BYTE: nbytes = CNT_W'(1);
            SZ_HALF: nbytes = CNT_W'(2);
            SZ_WORD: nbytes = CNT_W'(4);
            default: nbytes = CNT_W'(LINE_BYTES);
        endcase
        off_x      = {1'b0, off};
        misaligned = (off_x & (nbytes - 1'b1)) != '0;
        for (int i = 0; i < LINE_BYTES; i++) begin
            lane_mask[i] = (CNT_W'(i) >= off_x) && (CNT_W'(i) < off_x + nbytes);
        end
    end
endmodule

// File: rtl/qw_load_extract.sv
module qw_load_extract
    import qw_rmw_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int LINE_W = 8 * LINE_BYTES
) (
    input  logic [LINE_W-1:0] line,
    input  logic [OFF_W-1:0]  off,
    input  acc_size_e         size,
    output logic [31:0]       data
);
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            logic [OFF_W-1:0] idx;
            logic             keep;
            idx  = off + OFF_W'(k);
            keep = (k == 0) || (k == 1 && size != SZ_BYTE) ||
                   (k >= 2 && (size == SZ_WORD || size == SZ_QUAD));
            data[8*k +: 8] = keep ? line[{idx, 3'b000} +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/qw_store_merge.sv
module qw_store_merge #(
    parameter int LINE_BYTES = 16,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int LINE_W = 8 * LINE_BYTES
) (
    input  logic [LINE_W-1:0]     line,
    input  logic [LINE_W-1:0]     wdata,
    input  logic [OFF_W-1:0]      off,
    input  logic [LINE_BYTES-1:0] lane_mask,
    output logic [LINE_W-1:0]     merged
);
    logic [LINE_W-1:0] placed;

    assign placed = wdata << {off, 3'b000};

    for (genvar g = 0; g < LINE_BYTES; g++) begin : g_lane
        assign merged[8*g +: 8] = lane_mask[g] ? placed[8*g +: 8] : line[8*g +: 8];
    end
endmodule

// File: rtl/qw_rmw_adapter.sv
module qw_rmw_adapter
    import qw_rmw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINE_BYTES = 16,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int LINE_W = 8 * LINE_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LINE_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [31:0]       rsp_data,
    output logic [LINE_W-1:0] rsp_qdata,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic [LINE_W-1:0] mem_rdata
);
    typedef struct packed {
        fsm_e                    st;
        logic                    wr;
        acc_size_e               size;
        logic [OFF_W-1:0]        off;
        logic [ADDR_W-OFF_W-1:0] qidx;
        logic [LINE_W-1:0]       wdata;
        logic [LINE_W-1:0]       line;
        logic                    fault;
    } regs_t;

    regs_t d, q;

    acc_size_e            msk_size;
    logic [OFF_W-1:0]     msk_off;
    logic [LINE_BYTES-1:0] lane_mask;
    logic                 misaligned;
    logic                 idle;

    assign idle     = (q.st == ST_IDLE);
    assign msk_size = idle ? acc_size_e'(req_size) : q.size;
    assign msk_off  = idle ? req_addr[OFF_W-1:0] : q.off;

    qw_lane_mask #(.LINE_BYTES(LINE_BYTES)) u_mask (
        .size(msk_size), .off(msk_off), .lane_mask(lane_mask), .misaligned(misaligned)
    );

    qw_load_extract #(.LINE_BYTES(LINE_BYTES)) u_extract (
        .line(q.line), .off(q.off), .size(q.size), .data(rsp_data)
    );

    qw_store_merge #(.LINE_BYTES(LINE_BYTES)) u_merge (
        .line(q.line), .wdata(q.wdata), .off(q.off), .lane_mask(lane_mask), .merged(mem_wdata)
    );

    always_comb begin
        d       = q;
        d.fault = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.wr    = req_write;
                    d.size  = acc_size_e'(req_size);
                    d.off   = req_addr[OFF_W-1:0];
                    d.qidx  = req_addr[ADDR_W-1:OFF_W];
                    d.wdata = req_wdata;
                    if (misaligned)
                        d.fault = 1'b1;
                    else if (req_write && acc_size_e'(req_size) == SZ_QUAD)
                        d.st = ST_WRITE;
                    else
                        d.st = ST_READ;
                end
            end
            ST_READ:  d.st = ST_MERGE;
            ST_MERGE: begin
                d.line = mem_rdata;
                d.st   = q.wr ? ST_WRITE : ST_DONE;
            end
            ST_WRITE: d.st = ST_DONE;
            ST_DONE:  d.st = ST_IDLE;
            default:  d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready = idle;
    assign mem_rd_en = (q.st == ST_READ);
    assign mem_wr_en = (q.st == ST_WRITE);
    assign mem_addr  = {q.qidx, {OFF_W{1'b0}}};
    assign rsp_valid = (q.st == ST_DONE);
    assign rsp_fault = q.fault;
    assign rsp_qdata = q.line;

    p_line_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || mem_wr_en) |-> (mem_addr[OFF_W-1:0] == '0));

    p_fault_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (!mem_rd_en && !mem_wr_en && !rsp_valid && req_ready));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_rd_en && !mem_wr_en && !rsp_valid));

    p_no_rd_wr_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    p_one_response_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, rsp_fault}));

    p_read_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !misaligned && !(req_write && req_size == 2'b11))
        |=> mem_rd_en);

    p_quad_store_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && req_size == 2'b11 && req_addr[OFF_W-1:0] == '0)
        |=> (mem_wr_en && !mem_rd_en));

    p_write_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && q.size != SZ_QUAD) |-> ($past(mem_rd_en, 2) && !$past(mem_rd_en)));
endmodule

// File: tb/qw_rmw_adapter_bench.sv
`timescale 1ns/1ps
module qw_rmw_adapter_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [1:0]   req_size = 2'b00;
    logic [31:0]  req_addr = '0;
    logic [127:0] req_wdata = '0;
    logic         rsp_valid, rsp_fault;
    logic [31:0]  rsp_data;
    logic [127:0] rsp_qdata;
    logic         mem_rd_en, mem_wr_en;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [127:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    qw_rmw_adapter u_qw_rmw_adapter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_data(rsp_data), .rsp_qdata(rsp_qdata), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    logic [127:0] ram [16];
    logic [7:0]   shadow [256];

    always @(posedge clk) begin
        if (mem_wr_en) ram[mem_addr[7:4]] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= ram[mem_addr[7:4]];
    end

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int           rem = 0;
    int           lat = 0;
    bit           m_wr, m_quad, m_fault;
    logic [31:0]  e_data;
    logic [127:0] e_qdata;
    logic [31:0]  e_qaddr;

    always @(posedge clk) begin
        m_fault = 1'b0;
        if (!rst_n) begin
            rem = 0;
        end else if (rem > 0) begin
            rem--;
        end else if (req_valid) begin
            int nb, off, base;
            off  = int'(req_addr[3:0]);
            base = int'(req_addr[7:4]) * 16;
            nb   = (req_size == 2'b00) ? 1 : (req_size == 2'b01) ? 2 :
                   (req_size == 2'b10) ? 4 : 16;
            if ((off % nb) != 0) begin
                m_fault = 1'b1;
            end else begin
                m_wr    = req_write;
                m_quad  = (req_size == 2'b11);
                e_qaddr = {req_addr[31:4], 4'b0000};
                lat     = !m_wr ? 3 : (m_quad ? 2 : 4);
                rem     = lat;
                if (!m_wr) begin
                    e_data = '0;
                    for (int i = 0; i < 16; i++) e_qdata[8*i +: 8] = shadow[base + i];
                    for (int k = 0; k < nb && k < 4; k++) e_data[8*k +: 8] = shadow[base + off + k];
                end else begin
                    for (int k = 0; k < nb; k++) shadow[base + off + k] = req_wdata[8*k +: 8];
                end
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R8 ready", req_ready, rem == 0);
            chk("R4 R6 R7 rsp_valid", rsp_valid, rem == 1);
            chk("R3 fault", rsp_fault, m_fault);
            chk("R4 R6 R10 read strobe", mem_rd_en, rem > 0 && rem == lat && !(m_wr && m_quad));
            chk("R6 R7 write strobe", mem_wr_en, rem == 2 && m_wr);
            if (mem_rd_en || mem_wr_en) chk("R1 line address", mem_addr, e_qaddr);
            if (rsp_valid && !m_wr) begin
                if (m_quad) chk("R5 quad load", rsp_qdata, e_qdata);
                else        chk("R4 narrow load", {96'h0, rsp_data}, {96'h0, e_data});
            end
        end
    end

    task automatic issue(input bit wr, input logic [1:0] sz, input logic [31:0] a,
                         input logic [127:0] wd);
        while (rem != 0) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (rem != 0) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = 8'(i * 37 + 5);
        for (int j = 0; j < 16; j++)
            for (int i = 0; i < 16; i++) ram[j][8*i +: 8] = shadow[16*j + i];

        repeat (3) @(negedge clk);
        // R9: outputs during reset
        chk("R9 ready in reset", req_ready, 1'b1);
        chk("R9 quiet in reset", {rsp_valid, rsp_fault, mem_rd_en, mem_wr_en}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 ready after reset", req_ready, 1'b1);

        // R4 narrow loads, including halfword at address 2
        issue(0, 2'b01, 32'h02, '0);
        issue(0, 2'b00, 32'h05, '0);
        issue(0, 2'b10, 32'h0C, '0);
        issue(0, 2'b01, 32'h0E, '0);
        // R5 quadword load
        issue(0, 2'b11, 32'h20, '0);
        // R6 narrow stores, then read back
        issue(1, 2'b00, 32'h13, 128'hAB);
        issue(1, 2'b01, 32'h16, 128'hBEEF);
        issue(1, 2'b10, 32'h18, 128'hCAFE_F00D);
        issue(0, 2'b11, 32'h10, '0);
        // R7 quadword store, then read back
        issue(1, 2'b11, 32'h40, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
        issue(0, 2'b10, 32'h44, '0);
        issue(0, 2'b11, 32'h40, '0);
        // R2 R3 misaligned requests
        issue(0, 2'b01, 32'h03, '0);
        issue(1, 2'b10, 32'h06, 128'hFFFF_FFFF);
        issue(1, 2'b11, 32'h28, {4{32'hDEAD_BEEF}});
        issue(0, 2'b11, 32'h28, '0);
        issue(1, 2'b01, 32'h31, 128'h5555);
        issue(0, 2'b00, 32'h31, '0);

        // mixed random traffic
        for (int n = 0; n < 120; n++) begin
            logic [1:0]  sz;
            logic [31:0] a;
            sz = 2'($urandom_range(0, 3));
            a  = 32'($urandom_range(0, 255));
            if ($urandom_range(0, 3) != 0) begin
                case (sz)
                    2'b01:   a[0]   = 1'b0;
                    2'b10:   a[1:0] = 2'b00;
                    2'b11:   a[3:0] = 4'h0;
                    default: ;
                endcase
            end
            issue(1'($urandom_range(0, 1)), sz, a,
                  {$urandom, $urandom, $urandom, $urandom});
        end

        repeat (2) @(negedge clk);
        // R6 R7 R3: final contents line by line against the byte mirror
        for (int j = 0; j < 16; j++) begin
            logic [127:0] ex;
            for (int i = 0; i < 16; i++) ex[8*i +: 8] = shadow[16*j + i];
            chk("R6 R7 R3 final line", ram[j], ex);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule